// File: doc/BRIEF.md
# Segment Table Address Translator

This block converts a virtual address into a physical one by segment lookup. The upper bits of the incoming address pick one of a small number of table entries. The lower bits are an offset into that segment. Each entry holds a physical start address, a length, three permission bits and a valid flag. When the entry is present, the offset lies inside the segment and the access type is allowed, the result is the start address plus the offset. Otherwise the block returns a fault code, and the fault code tells the operating system which check failed.

Requests enter through a valid/ready handshake. The response comes back one cycle later from an output register, which stalls under backpressure. Software fills the table through a one-cycle write port that writes a whole entry at a time. Reset marks every entry absent.

Top module: `segxlat`

## Requirements
- R1: The segment number is the top SEG_BITS of `req_vaddr` and the offset is the low OFF_BITS. A successful translation returns `rsp_paddr` = entry base + offset, truncated to PA_BITS bits (the sum wraps).
- R2: `rsp_fault` uses these codes: 0 = no fault, 1 = not present, 2 = out of bounds, 3 = access refused. Whenever `rsp_fault` is non-zero, `rsp_paddr` is 0.
- R3: An offset greater than or equal to the entry length gives fault 2. The length field is OFF_BITS+1 bits wide, so a length of 2^OFF_BITS covers every offset, and a length of 0 refuses every offset.
- R4: Permission bits are bit0 = read, bit1 = write, bit2 = execute. `req_type` codes are 0 = read, 1 = write, 2 = execute, and 3 is reserved. A type whose bit is clear gives fault 3. Type 3 always gives fault 3.
- R5: An access to an entry whose valid flag is clear gives fault 1.
- R6: When several checks fail, the reported fault is chosen in this order: not present first, then out of bounds, then refused.
- R7: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result is shown with `rsp_valid` high right after that edge.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and `req_ready` is low.
- R9: A table write with `cfg_we` high takes effect at the clock edge. A request accepted at that same edge still sees the old entry, and every later request sees the new one.
- R10: After reset every entry is absent and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | SEG_BITS | Entry being written |
| cfg_base | input | PA_BITS | Physical start address of the segment |
| cfg_len | input | OFF_BITS+1 | Segment length |
| cfg_perm | input | 3 | Permission bits {execute, write, read} |
| cfg_valid | input | 1 | Entry present flag |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | SEG_BITS+OFF_BITS | Virtual address {segment, offset} |
| req_type | input | 2 | Access type |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_BITS | Translated address, 0 on a fault |
| rsp_fault | output | 2 | Fault code |

## Verification
The bench builds four segments with different shapes: a small read/write segment, a full-size execute-only segment, an absent entry, and a high segment whose sum wraps past the top of the physical space. A vector table then probes each segment at offset zero, at the last legal byte and at the first illegal byte, and with each access type. This separates off-by-one errors in the bounds check from mix-ups between permission bits and access types. Some vectors fail more than one check at once, so a wrong fault priority becomes visible. Directed tests cover the state after reset, a table write in the same cycle as a request, rewriting an entry to length zero, and a stalled response while a second request waits.

// File: rtl/segxlat.sv
module segxlat #(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [SEG_BITS-1:0]          cfg_idx,
  input  logic [PA_BITS-1:0]           cfg_base,
  input  logic [OFF_BITS:0]            cfg_len,
  input  logic [2:0]                   cfg_perm,
  input  logic                         cfg_valid,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [SEG_BITS+OFF_BITS-1:0] req_vaddr,
  input  logic [1:0]                   req_type,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [PA_BITS-1:0]           rsp_paddr,
  output logic [1:0]                   rsp_fault
);
  localparam int NSEG    = 1 << SEG_BITS;
  localparam int VA_BITS = SEG_BITS + OFF_BITS;
  localparam logic [1:0] F_NONE = 2'd0, F_ABSENT = 2'd1, F_BOUNDS = 2'd2, F_PERM = 2'd3;

  logic [PA_BITS-1:0]  base_q [NSEG];
  logic [OFF_BITS:0]   len_q  [NSEG];
  logic [2:0]          perm_q [NSEG];
  logic [NSEG-1:0]     vld_q;

  logic [SEG_BITS-1:0] seg;
  logic [OFF_BITS-1:0] off;
  logic                in_bounds, allowed, take;
  logic [1:0]          fault_d;
  logic [PA_BITS-1:0]  sum;

  assign seg       = req_vaddr[VA_BITS-1:OFF_BITS];
  assign off       = req_vaddr[OFF_BITS-1:0];
  assign in_bounds = {1'b0, off} < len_q[seg];
  assign sum       = base_q[seg] + PA_BITS'(off);
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    case (req_type)
      2'd0:    allowed = perm_q[seg][0];
      2'd1:    allowed = perm_q[seg][1];
      2'd2:    allowed = perm_q[seg][2];
      default: allowed = 1'b0;
    endcase
    if (!vld_q[seg])     fault_d = F_ABSENT;
    else if (!in_bounds) fault_d = F_BOUNDS;
    else if (!allowed)   fault_d = F_PERM;
    else                 fault_d = F_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (cfg_we) begin
      vld_q[cfg_idx]  <= cfg_valid;
      base_q[cfg_idx] <= cfg_base;
      len_q[cfg_idx]  <= cfg_len;
      perm_q[cfg_idx] <= cfg_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= F_NONE;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_fault <= fault_d;
      rsp_paddr <= (fault_d == F_NONE) ? sum : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

module segxlat_chk #(
  parameter int PA_BITS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PA_BITS-1:0] rsp_paddr,
  input logic [1:0]         rsp_fault
);
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0); // R2
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R8
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R8
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && rsp_ready) |=> !rsp_valid); // R7
endmodule

bind segxlat segxlat_chk #(.PA_BITS(PA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault)
);

// File: tb/segxlat_tb.sv
module segxlat_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0;
  logic [12:0] cfg_len = '0;
  logic [2:0]  cfg_perm = '0;
  logic        req_valid = 1'b0, rsp_ready = 1'b1;
  logic [13:0] req_vaddr = '0;
  logic [1:0]  req_type = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  int checks = 0, errors = 0, cyc = 0;

  segxlat u_dut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {type, segment, offset, fault, paddr}
  localparam logic [33:0] VEC [0:10] = '{
    {2'd0, 2'd0, 12'h000, 2'd0, 16'h1000},
    {2'd1, 2'd0, 12'h0FF, 2'd0, 16'h10FF},
    {2'd0, 2'd0, 12'h100, 2'd2, 16'h0000},
    {2'd2, 2'd0, 12'h010, 2'd3, 16'h0000},
    {2'd2, 2'd0, 12'h200, 2'd2, 16'h0000},
    {2'd0, 2'd2, 12'h000, 2'd1, 16'h0000},
    {2'd2, 2'd1, 12'hFFF, 2'd0, 16'h8FFF},
    {2'd0, 2'd1, 12'h000, 2'd3, 16'h0000},
    {2'd0, 2'd3, 12'hB00, 2'd0, 16'h0300},
    {2'd1, 2'd3, 12'hC00, 2'd2, 16'h0000},
    {2'd3, 2'd3, 12'h000, 2'd3, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] idx, input logic [15:0] base, input logic [12:0] len,
                     input logic [2:0] perm, input logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_len = len; cfg_perm = perm; cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(input logic [1:0] t, input logic [13:0] va, input logic [1:0] ef,
                       input logic [15:0] ep, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " fault"}, 32'(rsp_fault), 32'(ef));
    check({tag, " paddr"}, 32'(rsp_paddr), 32'(ep));
  endtask

  initial begin
    wait (cyc == 20000);
    errors++;
    $display("FAIL watchdog actual %0d expected done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R10 req_ready after reset", 32'(req_ready), 32'd1);
    xlate(2'd0, {2'd0, 12'h000}, 2'd1, 16'h0000, "R10 empty table");

    cfg(2'd0, 16'h1000, 13'h0100, 3'b011, 1'b1);
    cfg(2'd1, 16'h8000, 13'h1000, 3'b100, 1'b1);
    cfg(2'd2, 16'h4000, 13'h0000, 3'b111, 1'b0);
    cfg(2'd3, 16'hF800, 13'h0C00, 3'b111, 1'b1);

    for (int i = 0; i < 11; i++) begin
      string tag;
      case (VEC[i][17:16])
        2'd0: tag = "R1";
        2'd1: tag = "R5";
        2'd2: tag = "R3";
        default: tag = "R4";
      endcase
      if (i == 4) tag = "R6";
      xlate(VEC[i][33:32], VEC[i][31:18], VEC[i][17:16], VEC[i][15:0], $sformatf("%s vec%0d", tag, i));
    end

    // R6: absent entry with out-of-range offset and reserved type
    xlate(2'd3, {2'd2, 12'hFFF}, 2'd1, 16'h0000, "R6 absent first");

    // R9: write and request at the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_base = 16'h2000; cfg_len = 13'h0000; cfg_perm = 3'b111; cfg_valid = 1'b1;
    req_valid = 1'b1; req_type = 2'd0; req_vaddr = {2'd0, 12'h004};
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R9 old entry fault", 32'(rsp_fault), 32'd0);
    check("R9 old entry paddr", 32'(rsp_paddr), 32'h1004);
    xlate(2'd0, {2'd0, 12'h000}, 2'd2, 16'h0000, "R3 R9 zero length");

    // R8: backpressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_type = 2'd2; req_vaddr = {2'd1, 12'h010};
    @(negedge clk);
    req_type = 2'd0; req_vaddr = {2'd3, 12'h000};
    check("R8 first paddr", 32'(rsp_paddr), 32'h8010);
    check("R8 ready low", 32'(req_ready), 32'd0);
    @(negedge clk);
    check("R8 held valid", 32'(rsp_valid), 32'd1);
    check("R8 held paddr", 32'(rsp_paddr), 32'h8010);
    check("R8 held fault", 32'(rsp_fault), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 second valid", 32'(rsp_valid), 32'd1);
    check("R7 second paddr", 32'(rsp_paddr), 32'hF800);
    @(negedge clk);
    check("R7 drained", 32'(rsp_valid), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule